// File: doc/BRIEF.md
# Three-Wire Serial Register Port

A slave controller that gives an external host read and write access to a small bank of on-chip byte registers over three wires: an active-low select, a serial clock and one data line. Every access opens with a 16-bit header. The header carries a direction flag, a two-bit length code and a 13-bit start address. Whole 8-bit data words follow the header. After each word the address moves by one, so a single header can cover a block of registers. The length code picks a fixed one, two or three words, or an open-ended stream that runs until the host deselects.

The block samples the select, serial clock and data input on its own system clock, and it detects serial clock edges there. The data line is split into an input (`sdi`) and an output with an enable (`sdo`, `sdo_en`), which a pad cell outside this block joins into one bidirectional pin. Bit 0 of register 0 chooses the bit order. When it is clear, every field is sent most significant bit first and the address steps downward. When it is set, every field arrives least significant bit first, including the whole header, and the address steps upward.

Top module: `sra_port`

## Requirements
- R1: The header is 16 bits. In MSB-first order they are: bit 15 is the direction (1 = read, 0 = write), bits 14:13 are the length code, and bits 12:0 are the start address. `sdi` is sampled on the rising edge of `sclk`.
- R2: Length codes 00, 01 and 10 transfer exactly 1, 2 and 3 words. Bits that follow the last word, up to the rise of `cs_n`, write nothing and are never driven on `sdo`.
- R3: Length code 11 streams words for as long as `cs_n` stays low.
- R4: The first word uses the header address. Each later word uses the previous address minus one in MSB-first order, or plus one in LSB-first order.
- R5: The address is 13 bits wide and wraps. Stepping down from 0x0000 gives 0x1FFF, and stepping up from 0x1FFF gives 0x0000.
- R6: If `cs_n` rises partway through a word, that word is dropped. Words already completed are kept, and the next low period of `cs_n` begins with a fresh header.
- R7: After reset the order is MSB-first. Writing a 1 to bit 0 of register 0 selects LSB-first order. In that order the 16 header bits arrive reversed (address bit 0 first, direction bit last) and each data word arrives bit 0 first.
- R8: The bit order and the stepping direction are fixed when `cs_n` falls. A write to register 0 takes effect only from the next transaction.
- R9: `sdo_en` is high only during the data words of a read while `cs_n` is low. `sdo` changes only after a falling edge of `sclk`, and it carries the word's bits in the selected order.
- R10: Only addresses 0 to 63 hold storage. Any other address reads as 0x00, and writes to it change no register, including registers whose low address bits match.
- R11: Reset clears every register to 0x00 and holds `sdo_en` and `sdo` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; samples all serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Data line value seen at the pad |
| sdo | output | 1 | Read data toward the pad |
| sdo_en | output | 1 | Pad output enable for `sdo` |

## Verification
Every internal error reaches the ports within one transaction. A wrong header decode or a wrong step direction makes the words read back land at neighbouring or wrapped addresses. A wrong bit order returns bit-reversed bytes. A lost length count turns up as `sdo_en` that is high, or low, at the wrong bit, and the bench checks this before every `sclk` rise. A failed abort or failed order latching corrupts the very next readback. All 64 registers are swept through single-word writes and reads. The stream, wrap, abort and order-switch cases then run against an arithmetic model of the register bank.

// File: rtl/sra_pkg.sv
// Shared types for the serial register port.
// Assumes: one transaction is in flight at a time.
package sra_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,   // select inactive, or first cycle after it went active
        ST_HDR,    // shifting in the header
        ST_DATA,   // moving data words
        ST_DONE    // fixed length finished; ignore bits until deselect
    } sra_state_e;

    localparam logic [1:0] LEN_STREAM = 2'b11;
endpackage

// File: rtl/sra_sync.sv
// Brings cs_n, sclk and sdi into the clk domain and flags sclk edges.
// Assumes: sclk is slower than clk / 4 and sdi is stable around sclk rise.
module sra_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic cs_act,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic sdi_s
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] cs_p;
    logic [TOP:0] ck_p;
    logic [TOP:0] di_p;
    logic         ck_prev;

    // Shift each pin through its synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_p    <= '1;
            ck_p    <= '0;
            di_p    <= '0;
            ck_prev <= 1'b0;
        end else begin
            cs_p    <= {cs_p[TOP-1:0], cs_n};
            ck_p    <= {ck_p[TOP-1:0], sclk};
            di_p    <= {di_p[TOP-1:0], sdi};
            ck_prev <= ck_p[TOP];
        end
    end

    assign cs_act    = !cs_p[TOP];
    assign sclk_rise = ck_p[TOP] & !ck_prev;
    assign sclk_fall = !ck_p[TOP] & ck_prev;
    assign sdi_s     = di_p[TOP];
endmodule

// File: rtl/sra_regfile.sv
// Byte register bank. Only the low NUM_REGS addresses have storage.
// Assumes: NUM_REGS is a power of two and at most 2**ADDR_W.
module sra_regfile #(
    parameter int ADDR_W   = 13,
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              cfg_lsb
);
    localparam int IDX_W = $clog2(NUM_REGS);

    logic [DATA_W-1:0] mem [NUM_REGS];
    logic              hit;
    logic [IDX_W-1:0]  idx;

    assign hit = addr < ADDR_W'(NUM_REGS);
    assign idx = addr[IDX_W-1:0];

    // Clear on reset; store a written byte only for a decoded address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem[i] <= '0;
        end else if (wr_en && hit) begin
            mem[idx] <= wr_data;
        end
    end

    assign rd_data = hit ? mem[idx] : '0;
    assign cfg_lsb = mem[0][0];

    // R7: the order bit moves only after a write aimed at address zero.
    p_cfg_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_lsb) |-> $past(wr_en && addr == '0));
endmodule

// File: rtl/sra_engine.sv
// Header decoder, word counter, address generator and read shifter.
// Assumes: inputs already synchronized; rd_data is valid for addr_q
// in the same cycle.
module sra_engine
    import sra_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_act,
    input  logic              sclk_rise,
    input  logic              sclk_fall,
    input  logic              sdi_s,
    input  logic              cfg_lsb,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              sdo,
    output logic              sdo_en
);
    localparam int HDR_W = ADDR_W + 3;
    localparam int CNT_W = $clog2(HDR_W);
    localparam int BIT_W = $clog2(DATA_W);

    sra_state_e        st;
    logic              lsb_q;
    logic              rw_q;
    logic [1:0]        len_q;
    logic [1:0]        wleft;
    logic [HDR_W-1:0]  shreg;
    logic [HDR_W-1:0]  shift_nxt;
    logic [CNT_W-1:0]  cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_step;
    logic [BIT_W-1:0]  bit_idx;
    logic              out_q;
    logic              hdr_last;
    logic              byte_last;
    logic              word_done;

    // Next shift value: MSB-first fills from the bottom, LSB-first from the top.
    always_comb begin
        if (lsb_q) shift_nxt = {sdi_s, shreg[HDR_W-1:1]};
        else       shift_nxt = {shreg[HDR_W-2:0], sdi_s};
    end

    assign hdr_last  = cnt == CNT_W'(HDR_W - 1);
    assign byte_last = cnt == CNT_W'(DATA_W - 1);
    assign word_done = cs_act && st == ST_DATA && sclk_rise && byte_last;
    assign addr_step = lsb_q ? addr_q + 1'b1 : addr_q - 1'b1;
    assign bit_idx   = cnt[BIT_W-1:0];
    assign wr_en     = word_done && !rw_q;
    assign wr_data   = lsb_q ? shift_nxt[HDR_W-1 -: DATA_W] : shift_nxt[DATA_W-1:0];
    assign addr      = addr_q;

    // Transaction sequencer: header capture, word counting, address stepping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            lsb_q  <= 1'b0;
            rw_q   <= 1'b0;
            len_q  <= '0;
            wleft  <= '0;
            shreg  <= '0;
            cnt    <= '0;
            addr_q <= '0;
        end else if (!cs_act) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    st    <= ST_HDR;
                    lsb_q <= cfg_lsb;
                    cnt   <= '0;
                end
                ST_HDR: if (sclk_rise) begin
                    shreg <= shift_nxt;
                    cnt   <= cnt + 1'b1;
                    if (hdr_last) begin
                        rw_q   <= shift_nxt[HDR_W-1];
                        len_q  <= shift_nxt[HDR_W-2 -: 2];
                        wleft  <= shift_nxt[HDR_W-2 -: 2];
                        addr_q <= shift_nxt[ADDR_W-1:0];
                        cnt    <= '0;
                        st     <= ST_DATA;
                    end
                end
                ST_DATA: if (sclk_rise) begin
                    shreg <= shift_nxt;
                    cnt   <= cnt + 1'b1;
                    if (byte_last) begin
                        cnt    <= '0;
                        addr_q <= addr_step;
                        if (len_q != LEN_STREAM) begin
                            if (wleft == '0) st <= ST_DONE;
                            else             wleft <= wleft - 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // Present the next read bit after each falling sclk edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= 1'b0;
        end else if (sclk_fall && st == ST_DATA && rw_q) begin
            out_q <= lsb_q ? rd_data[bit_idx] : rd_data[BIT_W'(DATA_W - 1) - bit_idx];
        end
    end

    assign sdo    = out_q;
    assign sdo_en = cs_act && st == ST_DATA && rw_q;

    // R2: the finished state is reachable only for fixed-length codes.
    p_fixed_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st == ST_DONE |-> len_q != LEN_STREAM);
    // R6: losing the select always returns the sequencer to idle.
    p_abort_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |=> st == ST_IDLE);
    // R4: after a word the address moves one step in the latched direction.
    p_step_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && lsb_q) |=> addr_q == $past(addr_q) + 1'b1);
    // R9: the output bit never changes except after a falling sclk edge.
    p_sdo_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(out_q) |-> $past(sclk_fall));
endmodule

// File: rtl/sra_port.sv
// Top of the serial register port: synchronizer, engine and register bank.
// Assumes: an external pad joins sdi/sdo/sdo_en into one pin.
module sra_port #(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int NUM_REGS    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_en
);
    logic              cs_act;
    logic              sclk_rise;
    logic              sclk_fall;
    logic              sdi_s;
    logic              cfg_lsb;
    logic              wr_en;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] rd_data;

    sra_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s)
    );

    sra_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_act    (cs_act),
        .sclk_rise (sclk_rise),
        .sclk_fall (sclk_fall),
        .sdi_s     (sdi_s),
        .cfg_lsb   (cfg_lsb),
        .rd_data   (rd_data),
        .addr      (addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .sdo       (sdo),
        .sdo_en    (sdo_en)
    );

    sra_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .cfg_lsb (cfg_lsb)
    );
endmodule

// File: tb/sra_port_test.sv
module sra_port_test;
    localparam int HP = 6;   // clk cycles per sclk half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo;
    logic sdo_en;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mdl  [64];
    logic [7:0] wbuf [128];

    always #10 clk = ~clk;

    sra_port uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .sclk   (sclk),
        .sdi    (sdi),
        .sdo    (sdo),
        .sdo_en (sdo_en)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mread(input logic [12:0] a);
        return (a < 13'd64) ? mdl[a[5:0]] : 8'h00;
    endfunction

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One serial bit: drive sdi, sample outputs just before the rise.
    task automatic shift_bit(input logic b, input logic en_exp, output logic got);
        sdi = b;
        wait_clk(HP);
        got = sdo;
        check("R9 sdo_en", int'(sdo_en), int'(en_exp));
        sclk = 1'b1;
        wait_clk(HP);
        sclk = 1'b0;
    endtask

    // Full transaction with model update (writes) or comparison (reads).
    task automatic txn(input logic rw, input logic [1:0] len, input logic [12:0] a0,
                       input int nbytes, input int extra, input string req);
        logic        lsb;
        logic [15:0] hdr;
        logic [12:0] a;
        logic        got;
        logic [7:0]  rb;
        int          lim;
        lsb = mdl[0][0];
        hdr = {rw, len, a0};
        a   = a0;
        lim = (len == 2'b11) ? 32'h4000_0000 : int'(len) + 1;
        cs_n = 1'b0;
        wait_clk(HP);
        for (int i = 0; i < 16; i++) shift_bit(lsb ? hdr[i] : hdr[15-i], 1'b0, got);
        for (int w = 0; w < nbytes; w++) begin
            rb = 8'h00;
            for (int j = 0; j < 8; j++) begin
                int k = lsb ? j : 7 - j;
                shift_bit(wbuf[w][k], rw && (w < lim), got);
                rb[k] = got;
            end
            if (w < lim) begin
                if (rw) check(req, int'(rb), int'(mread(a)));
                else if (a < 13'd64) mdl[a[5:0]] = wbuf[w];
                a = lsb ? a + 1'b1 : a - 1'b1;
            end
        end
        for (int j = 0; j < extra; j++) shift_bit(1'b1, rw && (nbytes < lim), got);
        wait_clk(HP);
        cs_n = 1'b1;
        wait_clk(HP);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) mdl[i] = 8'h00;
        for (int i = 0; i < 128; i++) wbuf[i] = 8'h00;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R11: outputs quiet, all registers zero after reset.
        check("R11 sdo_en", int'(sdo_en), 0);
        check("R11 sdo", int'(sdo), 0);
        txn(1'b1, 2'b11, 13'd63, 64, 0, "R11 reset contents");

        // R1: single-word write and read of every register.
        for (int a = 1; a < 64; a++) begin
            wbuf[0] = 8'(a * 37 + 11);
            txn(1'b0, 2'b00, 13'(a), 1, 0, "R1 write");
        end
        for (int a = 0; a < 64; a++) txn(1'b1, 2'b00, 13'(a), 1, 0, "R1 readback");

        // R10: unbacked addresses read zero and do not alias.
        wbuf[0] = 8'h5B;
        txn(1'b0, 2'b00, 13'h0040, 1, 0, "R10 write");
        txn(1'b0, 2'b00, 13'h1005, 1, 0, "R10 write");
        txn(1'b1, 2'b00, 13'h0040, 1, 0, "R10 read 0x40");
        txn(1'b1, 2'b00, 13'h1005, 1, 0, "R10 read 0x1005");
        txn(1'b1, 2'b00, 13'h0000, 1, 0, "R10 no alias reg0");
        txn(1'b1, 2'b00, 13'h0005, 1, 0, "R10 no alias reg5");

        // R2: fixed lengths stop after 1, 2 or 3 words.
        wbuf[0] = 8'hC1; wbuf[1] = 8'h72; wbuf[2] = 8'h1E; wbuf[3] = 8'hE4;
        txn(1'b0, 2'b01, 13'd20, 4, 0, "R2 write");
        txn(1'b1, 2'b11, 13'd20, 4, 0, "R2 two words");
        txn(1'b0, 2'b10, 13'd30, 4, 0, "R2 write");
        txn(1'b1, 2'b11, 13'd30, 4, 0, "R2 three words");
        txn(1'b1, 2'b00, 13'd40, 2, 0, "R2 read stops");

        // R3 and R4: long stream downward in MSB-first order.
        for (int w = 0; w < 63; w++) wbuf[w] = 8'(w * 13 + 7);
        txn(1'b0, 2'b11, 13'd63, 63, 0, "R3 write");
        txn(1'b1, 2'b11, 13'd63, 63, 0, "R3 R4 stream decrement");

        // R5: downward wrap from 0x0000 to 0x1FFF.
        wbuf[0] = 8'h81; wbuf[1] = 8'h22; wbuf[2] = 8'h99;
        txn(1'b0, 2'b11, 13'd1, 3, 0, "R5 write");
        txn(1'b1, 2'b11, 13'd1, 3, 0, "R5 wrap down");

        // R6: partial second word is dropped; next header works.
        wbuf[0] = 8'hC3; wbuf[1] = 8'h3C;
        txn(1'b0, 2'b01, 13'd10, 1, 5, "R6 write");
        txn(1'b1, 2'b01, 13'd10, 2, 0, "R6 abort");
        txn(1'b1, 2'b00, 13'd10, 1, 3, "R6 read abort");
        txn(1'b1, 2'b00, 13'd9, 1, 0, "R6 next header");

        // R7: switch to LSB-first, read upward.
        wbuf[0] = 8'h01;
        txn(1'b0, 2'b00, 13'd0, 1, 0, "R7 write cfg");
        txn(1'b1, 2'b11, 13'd5, 3, 0, "R7 lsb read increment");

        // R8 and R5: order held while cfg is cleared mid-stream; upward wrap.
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h00; wbuf[3] = 8'hA1; wbuf[4] = 8'h3C;
        txn(1'b0, 2'b11, 13'h1FFE, 5, 0, "R8 write");
        txn(1'b1, 2'b11, 13'd2, 3, 0, "R8 order held");
        txn(1'b1, 2'b00, 13'h1FFF, 1, 0, "R5 wrap up");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule